// File: doc/BRIEF.md
# Interval Timer Latch and Readback Unit

This block is the readback side of a three-channel interval timer. It takes one 8-bit control write port and returns bytes from the three counter data ports. For each channel it receives the live 16-bit count, the OUT level, the null-count flag and the programmed 6-bit mode field. The counting, gating and loading logic sits elsewhere.

Two commands are decoded. The single-counter latch command freezes one count. The multi-counter read-back command can freeze the count, the status, or both, on any set of channels. Each channel tracks its own latched state and its own byte order, so reads to different channels can be interleaved freely. When a channel is reprogrammed, a strobe from the programming logic clears that channel's frozen values and its byte pointer.

Top module: `timer_readback`

## Requirements
- R1: After synchronous reset, `rd_data` is 0, no channel holds a frozen count or status, and every channel's next byte is its low byte.
- R2: A control write whose bits 7:6 are 11 is a read-back command. Bit 5 low freezes the count and bit 4 low freezes the status, so both low freezes both. Bits 1, 2 and 3 select channels 0, 1 and 2, and any combination of them may be set.
- R3: A control write whose bits 7:6 are 00, 01 or 10 and whose bits 5:4 are 00 freezes the count of channel 0, 1 or 2.
- R4: While a channel holds a frozen count, further count-freeze requests to it are ignored until every byte of that count has been read. The frozen status follows the same rule on its own.
- R5: When a channel holds a frozen status, the next read of that channel returns the status. Reads after that return the frozen count bytes, if any, and then the live count.
- R6: When `fmt_two[i]` is 0, each read returns the low byte and a frozen count is released after one read. When it is 1, reads alternate low byte then high byte, and a frozen count is released after its high byte.
- R7: Each channel keeps its own frozen values and byte pointer. Reads, commands and reprogramming of other channels between two reads of a channel leave its sequence unchanged.
- R8: A read with `rd_en` high and `rd_port` equal to 0, 1 or 2 reads channel 0, 1 or 2. The byte appears on `rd_data` after the next rising clock edge and holds until the next read.
- R9: A pulse on `prog[i]` clears channel i's frozen count, frozen status and byte pointer.
- R10: The status byte holds OUT in bit 7, null-count in bit 6 and the mode field in bits 5:0, all sampled in the cycle the status is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_data | input | 8 | Control word |
| rd_en | input | 1 | Data port read strobe |
| rd_port | input | 2 | Data port offset (0 to 2) |
| rd_data | output | 8 | Registered read byte |
| prog | input | 3 | Per-channel reprogram strobe |
| fmt_two | input | 3 | Per-channel access format: 1 is two bytes, 0 is one byte |
| live_count | input | 48 | Live counts, channel i at bits 16i+15:16i |
| out_level | input | 3 | Per-channel OUT level |
| null_flag | input | 3 | Per-channel null-count flag |
| mode_field | input | 18 | Mode fields, channel i at bits 6i+5:6i |

## Verification
The bench builds the block with its default of three channels and 16-bit counts. At that size every read-back select pattern, every count/status latch kind and every mix of one-byte and two-byte formats can be swept exhaustively, 256 combinations in all. After each command the live inputs are changed, so frozen values and live values always differ. The reads are interleaved round-robin across the channels and run past the end of the frozen data. Repeated latches and mid-sequence reprogramming are covered by directed sequences.

// File: rtl/tmr_rb_pkg.sv
package tmr_rb_pkg;
  localparam int CNT_W  = 16;
  localparam int MODE_W = 6;
  localparam int BYTE_W = 8;

  function automatic logic [BYTE_W-1:0] pack_status(input logic out_lvl,
                                                    input logic null_cnt,
                                                    input logic [MODE_W-1:0] mode);
    return {out_lvl, null_cnt, mode};
  endfunction
endpackage

// File: rtl/tmr_rb_decode.sv
module tmr_rb_decode #(
  parameter int N_CH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_wr,
  input  logic [7:0]      ctl_data,
  output logic [N_CH-1:0] lat_cnt,
  output logic [N_CH-1:0] lat_sts
);
  localparam logic [1:0] RB_CODE = 2'b11;

  always_comb begin
    lat_cnt = '0;
    lat_sts = '0;
    if (ctl_wr) begin
      if (ctl_data[7:6] == RB_CODE) begin
        for (int i = 0; i < N_CH; i++) begin
          if (ctl_data[i+1]) begin
            lat_cnt[i] = ~ctl_data[5];
            lat_sts[i] = ~ctl_data[4];
          end
        end
      end else if (ctl_data[5:4] == 2'b00) begin
        for (int i = 0; i < N_CH; i++)
          if (ctl_data[7:6] == 2'(i)) lat_cnt[i] = 1'b1;
      end
    end
  end

  // R3: a single-counter latch touches at most one channel and never status
  assert_single_latch_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_data[7:6] != RB_CODE) |-> ($onehot0(lat_cnt) && lat_sts == '0));
endmodule

// File: rtl/tmr_rb_chan.sv
module tmr_rb_chan
  import tmr_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              prog,
  input  logic              fmt_two,
  input  logic              lat_cnt,
  input  logic              lat_sts,
  input  logic              rd_stb,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic [BYTE_W-1:0] sts_in,
  output logic [BYTE_W-1:0] rd_byte
);
  logic              cnt_held, sts_held, byte_hi;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sts_q;
  logic [CNT_W-1:0]  src;

  always_ff @(posedge clk) begin
    if (rst || prog) begin
      cnt_held <= 1'b0;
      sts_held <= 1'b0;
      byte_hi  <= 1'b0;
      cnt_q    <= '0;
      sts_q    <= '0;
    end else begin
      if (lat_cnt && !cnt_held) begin
        cnt_held <= 1'b1;
        cnt_q    <= live_cnt;
      end
      if (lat_sts && !sts_held) begin
        sts_held <= 1'b1;
        sts_q    <= sts_in;
      end
      if (rd_stb) begin
        if (sts_held) begin
          sts_held <= 1'b0;
        end else if (cnt_held) begin
          if (!fmt_two || byte_hi) cnt_held <= 1'b0;
          if (fmt_two) byte_hi <= ~byte_hi;
        end else if (fmt_two) begin
          byte_hi <= ~byte_hi;
        end
      end
    end
  end

  always_comb begin
    src = cnt_held ? cnt_q : live_cnt;
    if (sts_held)               rd_byte = sts_q;
    else if (fmt_two && byte_hi) rd_byte = src[15:8];
    else                         rd_byte = src[7:0];
  end

  // R4: a held count is not overwritten by a repeated latch
  assert_hold_count_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_held && lat_cnt && !rd_stb && !prog) |=> (cnt_held && $stable(cnt_q)));
  // R4: a held status is not overwritten by a repeated latch
  assert_hold_status_R4: assert property (@(posedge clk) disable iff (rst)
    (sts_held && lat_sts && !rd_stb && !prog) |=> (sts_held && $stable(sts_q)));
  // R5: reading a held status leaves the count state untouched
  assert_status_first_R5: assert property (@(posedge clk) disable iff (rst)
    (sts_held && rd_stb && !prog && !lat_sts) |=> (!sts_held && $stable(cnt_held) && $stable(byte_hi)));
  // R6: in one-byte format a held count is released by one read
  assert_one_byte_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_held && !sts_held && rd_stb && !fmt_two && !prog) |=> !cnt_held);
  // R9: reprogramming clears everything
  assert_prog_clear_R9: assert property (@(posedge clk) disable iff (rst)
    prog |=> (!cnt_held && !sts_held && !byte_hi));
endmodule

// File: rtl/timer_readback.sv
module timer_readback
  import tmr_rb_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctl_wr,
  input  logic [7:0]            ctl_data,
  input  logic                  rd_en,
  input  logic [1:0]            rd_port,
  output logic [7:0]            rd_data,
  input  logic [N_CH-1:0]       prog,
  input  logic [N_CH-1:0]       fmt_two,
  input  logic [N_CH*CNT_W-1:0] live_count,
  input  logic [N_CH-1:0]       out_level,
  input  logic [N_CH-1:0]       null_flag,
  input  logic [N_CH*MODE_W-1:0] mode_field
);
  logic [N_CH-1:0]   lat_cnt, lat_sts;
  logic [BYTE_W-1:0] ch_byte [N_CH];
  logic [BYTE_W-1:0] sel_byte;

  tmr_rb_decode #(.N_CH(N_CH)) u_dec (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .lat_cnt(lat_cnt), .lat_sts(lat_sts)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr_rb_chan u_ch (
      .clk(clk), .rst(rst), .prog(prog[g]), .fmt_two(fmt_two[g]),
      .lat_cnt(lat_cnt[g]), .lat_sts(lat_sts[g]),
      .rd_stb(rd_en && rd_port == 2'(g)),
      .live_cnt(live_count[g*CNT_W +: CNT_W]),
      .sts_in(pack_status(out_level[g], null_flag[g], mode_field[g*MODE_W +: MODE_W])),
      .rd_byte(ch_byte[g])
    );
  end

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < N_CH; i++)
      if (rd_port == 2'(i)) sel_byte = ch_byte[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_byte;
  end

  // R8: rd_data holds while no read is issued
  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/timer_readback_test.sv
`timescale 1ns/1ps
module timer_readback_test;
  localparam int N = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, ctl_wr, rd_en;
  logic [7:0] ctl_data, rd_data;
  logic [1:0] rd_port;
  logic [N-1:0] prog, fmt, outl, nulf;
  logic [15:0] live [N];
  logic [5:0]  mode [N];
  logic [N*16-1:0] live_bus;
  logic [N*6-1:0]  mode_bus;

  always_comb
    for (int i = 0; i < N; i++) begin
      live_bus[i*16 +: 16] = live[i];
      mode_bus[i*6 +: 6]   = mode[i];
    end

  timer_readback uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .rd_en(rd_en), .rd_port(rd_port), .rd_data(rd_data),
    .prog(prog), .fmt_two(fmt), .live_count(live_bus),
    .out_level(outl), .null_flag(nulf), .mode_field(mode_bus)
  );

  int vectors = 0, errors = 0;
  logic        m_ch [N], m_sh [N], m_hi [N];
  logic [15:0] m_cnt [N];
  logic [7:0]  m_sts [N];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear(input int c);
    m_ch[c] = 0; m_sh[c] = 0; m_hi[c] = 0;
  endtask

  task automatic model_cmd(input logic [7:0] d);
    for (int c = 0; c < N; c++) begin
      logic lc, ls;
      lc = 0; ls = 0;
      if (d[7:6] == 2'b11) begin
        if (d[c+1]) begin lc = !d[5]; ls = !d[4]; end
      end else if (d[5:4] == 2'b00 && d[7:6] == 2'(c)) lc = 1;
      if (lc && !m_ch[c]) begin m_ch[c] = 1; m_cnt[c] = live[c]; end
      if (ls && !m_sh[c]) begin m_sh[c] = 1; m_sts[c] = {outl[c], nulf[c], mode[c]}; end
    end
  endtask

  function automatic logic [7:0] model_peek(input int c);
    logic [15:0] s;
    s = m_ch[c] ? m_cnt[c] : live[c];
    if (m_sh[c]) return m_sts[c];
    return (fmt[c] && m_hi[c]) ? s[15:8] : s[7:0];
  endfunction

  task automatic model_adv(input int c);
    if (m_sh[c]) m_sh[c] = 0;
    else begin
      if (m_ch[c] && (!fmt[c] || m_hi[c])) m_ch[c] = 0;
      if (fmt[c]) m_hi[c] = !m_hi[c];
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_data = d;
    model_cmd(d);
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic rd(input int c, input string req);
    logic [7:0] e;
    @(negedge clk); rd_en = 1; rd_port = 2'(c);
    e = model_peek(c); model_adv(c);
    @(negedge clk); rd_en = 0;
    chk(req, rd_data, e);
  endtask

  task automatic do_prog(input logic [N-1:0] m);
    @(negedge clk); prog = m;
    for (int c = 0; c < N; c++) if (m[c]) model_clear(c);
    @(negedge clk); prog = '0;
  endtask

  task automatic perturb(input int k);
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      live[c] = live[c] + 16'h0111 + 16'(k);
      mode[c] = mode[c] + 6'd5;
    end
    outl = ~outl; nulf = nulf ^ 3'b101;
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    rst = 1; ctl_wr = 0; ctl_data = 0; rd_en = 0; rd_port = 0;
    prog = 0; fmt = 0; outl = 0; nulf = 0;
    for (int c = 0; c < N; c++) begin
      live[c] = 16'h1234 + 16'(c * 16'h2111); mode[c] = 6'(c + 3); model_clear(c);
    end
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 reset rd_data", rd_data, 8'h00);
    fmt = 3'b111;
    rd(0, "R1 live low byte after reset");
    rd(0, "R1 live high byte after reset");

    // Exhaustive sweep: format mix x channel select x latch kind
    for (int fm = 0; fm < 8; fm++)
      for (int sel = 0; sel < 8; sel++)
        for (int kind = 0; kind < 4; kind++) begin
          @(negedge clk); fmt = 3'(fm);
          for (int c = 0; c < N; c++) live[c] = 16'((fm << 12) ^ (sel << 8) ^ (kind << 4) ^ (c * 16'h3A5B));
          outl = 3'(sel); nulf = 3'(kind);
          do_prog(3'b111);
          wr_ctl({2'b11, 2'(kind), 3'(sel), 1'b0});
          perturb(kind);
          for (int r = 0; r < 4; r++)
            for (int c = 0; c < N; c++)
              rd(c, "R2 R5 R6 R7 R8 R10 read-back sweep");
        end

    // Single-counter latch with repeated latch ignored
    for (int fm = 0; fm < 2; fm++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk); fmt = fm ? 3'b111 : 3'b000;
        do_prog(3'b111);
        wr_ctl({2'(c), 2'b00, 4'b0000});
        perturb(1);
        wr_ctl({2'(c), 2'b00, 4'b0000});
        perturb(2);
        for (int r = 0; r < 3; r++)
          for (int k = 0; k < N; k++)
            rd(k, "R3 R4 counter latch and repeat ignored");
      end

    // Repeated status latch ignored; status ahead of held count
    @(negedge clk); fmt = 3'b010;
    do_prog(3'b111);
    wr_ctl(8'hE4);              // status only, channel 1
    perturb(3);
    wr_ctl(8'hC4);              // count and status, channel 1: status ignored
    perturb(4);
    wr_ctl(8'h40);              // counter latch on channel 1: ignored (held)
    perturb(5);
    for (int r = 0; r < 4; r++) rd(1, "R4 R5 held status then count");

    // Reprogram mid-sequence clears state
    @(negedge clk); fmt = 3'b111;
    do_prog(3'b111);
    wr_ctl(8'hC2);              // both, channel 0
    perturb(6);
    rd(0, "R9 status before prog");
    rd(0, "R9 count low before prog");
    do_prog(3'b001);
    rd(0, "R9 live low after prog");
    rd(0, "R9 live high after prog");

    // Interleaved partial reads with other-channel activity
    do_prog(3'b111);
    wr_ctl(8'h00);
    rd(0, "R7 ch0 low");
    wr_ctl(8'h80);
    perturb(7);
    rd(2, "R7 ch2 low");
    do_prog(3'b010);
    rd(0, "R7 ch0 high");
    rd(2, "R7 ch2 high");
    rd(1, "R7 ch1 live");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule